// File: doc/BRIEF.md
# I2C Bus Condition Monitor

A passive observer for a two-wire I2C bus. It brings the raw clock line (SCL) and data line (SDA) into the local clock domain through a parameterised synchroniser. It then compares each synchronised level with the level registered one cycle earlier. From this it reports bus conditions as single-cycle pulses: a first start, a repeated start and a stop. It never drives either line.

Alongside the pulses it keeps a level flag that shows whether the bus is owned by some master. A local master can use this flag to decide when it may begin a transfer, or when it may retry one after losing arbitration. While the bus is owned, the monitor counts SCL rising edges within the current frame. On the edge that carries the acknowledge bit it emits a one-cycle marker together with the sampled SDA level. Setup and hold timing on the lines is not checked.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, every pulse output is 0, `bus_busy` is 0, `ack_sda` is 1, and no condition is reported while both lines stay high.
- R2: When SDA falls while SCL stays high and the bus is idle, `start_p` pulses for exactly one clock cycle, and `bus_busy` becomes 1.
- R3: When SDA rises while SCL stays high, `stop_p` pulses for exactly one clock cycle and `bus_busy` becomes 0.
- R4: When SDA falls while SCL stays high and the bus is already busy, `rstart_p` pulses for one cycle instead of `start_p`, and `bus_busy` stays 1.
- R5: Any change of SDA while SCL is low produces no start, repeated start or stop pulse.
- R6: While the bus is busy, the `FRAME_BITS`-th SCL rising edge of a frame (9 by default) raises `ack_slot` for one cycle. In that same cycle `ack_sda` holds the SDA level sampled on that edge (0 = acknowledge, 1 = no acknowledge). The frame count then restarts.
- R7: The SCL rising-edge count returns to zero on every start, repeated start and stop, so a frame that a repeated start cuts short does not shift the next acknowledge slot.
- R8: SCL rising edges while the bus is idle are not counted, so the first frame after a start still marks its acknowledge on its 9th rising edge.
- R9: Each condition pulse and each acknowledge marker appears `SYNC_STAGES`+1 clock cycles after the line change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| start_p | output | 1 | One-cycle pulse on a start seen from idle |
| rstart_p | output | 1 | One-cycle pulse on a start seen while busy |
| stop_p | output | 1 | One-cycle pulse on a stop |
| bus_busy | output | 1 | Level: bus owned by a master |
| ack_slot | output | 1 | One-cycle pulse on the acknowledge clock edge |
| ack_sda | output | 1 | SDA level captured at the last acknowledge slot |

## Verification
The assertions take for granted that SCL and SDA never change in the same synchronised cycle. If they did, a simultaneous SCL fall and SDA edge could look like a condition. The assertions also assume each line level holds for at least two clock cycles. The stimulus meets both assumptions: it changes one line per step and holds every level for several more cycles than the synchroniser depth. SDA is moved only while SCL is low, except where a start, repeated start or stop is intended.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

   // bus condition decoded from one pair of synchronised samples
   typedef struct packed {
      logic first_start;
      logic again_start;
      logic halt;
   } bus_cond_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("i2cmon_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond
   import i2cmon_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      scl_s,
   input  logic      sda_s,
   output bus_cond_t cond_now,
   output logic      scl_rise,
   output logic      busy_q,
   output bus_cond_t cond_q
);

   logic scl_prev, sda_prev;
   logic sda_fall_hi, sda_rise_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign sda_fall_hi = scl_s & scl_prev & sda_prev & ~sda_s;
   assign sda_rise_hi = scl_s & scl_prev & ~sda_prev & sda_s;
   assign scl_rise    = scl_s & ~scl_prev;

   always_comb begin
      cond_now.first_start = sda_fall_hi & ~busy_q;
      cond_now.again_start = sda_fall_hi & busy_q;
      cond_now.halt        = sda_rise_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cond_q <= '0;
      end else begin
         cond_q <= cond_now;
         if (sda_rise_hi)      busy_q <= 1'b0;
         else if (sda_fall_hi) busy_q <= 1'b1;
      end
   end

   AST_FIRST_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cond_q.first_start |-> busy_q); // R2
   AST_HALT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cond_q.halt |-> !busy_q); // R3
   AST_AGAIN_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cond_q.again_start |-> (busy_q && $past(busy_q))); // R4
   AST_ONE_COND: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cond_q.first_start, cond_q.again_start, cond_q.halt})); // R4
   AST_COND_NEEDS_SCL_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_now.first_start || cond_now.again_start || cond_now.halt)
         |-> (scl_s && $stable(scl_s))); // R5

endmodule

// File: rtl/i2cmon_frame.sv
module i2cmon_frame
   import i2cmon_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_rise,
   input  logic sda_s,
   input  logic busy,
   input  logic restart,
   output logic ack_slot,
   output logic ack_sda
);

   localparam int unsigned CNT_W = cnt_width(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("i2cmon_frame: FRAME_BITS must be at least 2");
   end

   logic [CNT_W-1:0] rises;
   logic             at_last;

   assign at_last = (rises == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rises    <= '0;
         ack_slot <= 1'b0;
         ack_sda  <= 1'b1;
      end else begin
         ack_slot <= 1'b0;
         if (restart) begin
            rises <= '0;
         end else if (scl_rise && busy) begin
            if (at_last) begin
               rises    <= '0;
               ack_slot <= 1'b1;
               ack_sda  <= sda_s;
            end else begin
               rises <= rises + 1'b1;
            end
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rises <= LAST); // R7
   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_slot |=> !ack_slot); // R6
   AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !restart) |=> $stable(rises)); // R8

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
   import i2cmon_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FRAME_BITS  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic start_p,
   output logic rstart_p,
   output logic stop_p,
   output logic bus_busy,
   output logic ack_slot,
   output logic ack_sda
);

   logic      scl_s, sda_s, scl_rise, busy_q;
   bus_cond_t cond_now, cond_q;

   i2cmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

   i2cmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   i2cmon_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .cond_now(cond_now), .scl_rise(scl_rise), .busy_q(busy_q),
      .cond_q(cond_q));

   i2cmon_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .sda_s(sda_s),
      .busy(busy_q),
      .restart(cond_now.first_start | cond_now.again_start | cond_now.halt),
      .ack_slot(ack_slot), .ack_sda(ack_sda));

   assign start_p  = cond_q.first_start;
   assign rstart_p = cond_q.again_start;
   assign stop_p   = cond_q.halt;
   assign bus_busy = busy_q;

   AST_ACK_APART_FROM_COND: assert property (@(posedge clk) disable iff (!rst_n)
      ack_slot |-> !(start_p || rstart_p || stop_p)); // R6
   AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ack_slot |-> $past(bus_busy)); // R8

endmodule

// File: tb/sim_i2c_bus_monitor.sv
module sim_i2c_bus_monitor;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int HOLD       = SYNC + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic start_p, rstart_p, stop_p, bus_busy, ack_slot, ack_sda;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_bus_monitor #(.SYNC_STAGES(SYNC), .FRAME_BITS(9)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
      .start_p(start_p), .rstart_p(rstart_p), .stop_p(stop_p),
      .bus_busy(bus_busy), .ack_slot(ack_slot), .ack_sda(ack_sda));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // counts {start, rstart, stop, ack} packed as 4 nibbles, plus busy
   task automatic step(input logic c, input logic d, input string req,
                       input int n_st, input int n_rs, input int n_sp,
                       input int n_ak, input logic exp_busy,
                       input int exp_ackv);
      int cs = 0, cr = 0, cp = 0, ca = 0, av = -1, lat = -1;
      @(negedge clk);
      scl = c; sda = d;
      for (int k = 1; k <= HOLD; k++) begin
         @(negedge clk);
         if (start_p || rstart_p || stop_p || ack_slot)
            if (lat < 0) lat = k;
         cs += int'(start_p); cr += int'(rstart_p);
         cp += int'(stop_p);  ca += int'(ack_slot);
         if (ack_slot) av = int'(ack_sda);
      end
      check({req, " counts"}, (cs << 12) | (cr << 8) | (cp << 4) | ca,
            (n_st << 12) | (n_rs << 8) | (n_sp << 4) | n_ak);
      check({req, " busy"}, int'(bus_busy), int'(exp_busy));
      if (n_ak != 0) check("R6 ack value", av, exp_ackv);
      if (n_st + n_rs + n_sp + n_ak != 0)
         check("R9 latency", lat, SYNC + 1);
   endtask

   logic cur_sda;

   // clock one bit: SDA set while SCL low, then SCL high
   task automatic send_bit(input logic b, input logic busy_now,
                           input bit is_ack, input string req);
      step(1'b0, cur_sda, "R5 scl fall", 0,0,0,0, busy_now, 0);
      step(1'b0, b,       "R5 sda move low", 0,0,0,0, busy_now, 0);
      cur_sda = b;
      step(1'b1, b, req, 0,0,0, is_ack ? 1 : 0, busy_now, int'(b));
   endtask

   task automatic send_frame(input logic [7:0] v, input logic ak);
      for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b1, 0, "R6 data bit");
      send_bit(ak, 1'b1, 1, "R6 ack edge");
   endtask

   task automatic do_start(input bit busy_before);
      if (busy_before) begin
         step(1'b0, cur_sda, "R5 pre-rs", 0,0,0,0, 1'b1, 0);
         step(1'b0, 1'b1,    "R5 pre-rs sda", 0,0,0,0, 1'b1, 0);
         step(1'b1, 1'b1,    "R5 pre-rs scl", 0,0,0,0, 1'b1, 0);
         step(1'b1, 1'b0,    "R4 repeated start", 0,1,0,0, 1'b1, 0);
      end else begin
         step(1'b1, 1'b0,    "R2 start", 1,0,0,0, 1'b1, 0);
      end
      cur_sda = 1'b0;
   endtask

   task automatic do_stop();
      step(1'b0, cur_sda, "R5 pre-stop", 0,0,0,0, 1'b1, 0);
      step(1'b0, 1'b0,    "R5 pre-stop sda", 0,0,0,0, 1'b1, 0);
      step(1'b1, 1'b0,    "R5 pre-stop scl", 0,0,0,0, 1'b1, 0);
      step(1'b1, 1'b1,    "R3 stop", 0,0,1,0, 1'b0, 0);
      cur_sda = 1'b1;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      bit busy_now;
      cur_sda = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, lines idle
      step(1'b1, 1'b1, "R1 idle", 0,0,0,0, 1'b0, 0);
      check("R1 ack_sda reset", int'(ack_sda), 1);

      // R8: SCL pulses while idle are not counted
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1, "R8 idle low", 0,0,0,0, 1'b0, 0);
         step(1'b1, 1'b1, "R8 idle high", 0,0,0,0, 1'b0, 0);
      end
      do_start(0);
      send_frame(8'hA5, 1'b0);

      // R7: repeated start after three bits restarts the frame count
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1, 0, "R7 partial");
      do_start(1);
      send_frame(8'h3C, 1'b1);
      do_stop();

      // sweep over every byte value, mixing start kinds and stops
      busy_now = 1'b0;
      for (int v = 0; v < 256; v++) begin
         do_start(busy_now);
         busy_now = 1'b1;
         send_frame(v[7:0], v[3]);
         if ((v % 4) == 3) begin
            do_stop();
            busy_now = 1'b0;
         end
      end
      if (busy_now) do_stop();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule